// File: doc/BRIEF.md
# Wrapping Burst Read Sequencer

This block is the read-side front end of a word-wide memory that serves two kinds of read. In asynchronous mode the memory array address simply follows the incoming word address, and data is flagged valid whenever chip enable and output enable are both low. In burst mode, the block captures a starting word address on a clock edge and then walks through the aligned 32-word block that contains it. The walk starts at any word in the block, wraps from the top of the block back to its base, and signals the 32nd word of the burst with an active-low indicator.

Mode changes come from two strobes that stand for command sequences already decoded elsewhere: one enters burst mode and the other leaves it. A burst can end in three ways. Raising chip enable ends the burst but keeps burst mode. The disable strobe returns the block to asynchronous mode. Pulling the reset input low clears everything at once. The delay from loading the address to the first valid word is a parameter counted in clocks.

Top module: `burst_read_seq`

## Requirements
- R1: While the reset input is low, and after it is released, the block is in asynchronous mode with `last_n` high. Reset acts at once and does not wait for a clock edge.
- R2: In asynchronous mode, `mem_addr` equals `addr_in`, `data_valid` is high exactly when `ce_n` and `oe_n` are both low, and `last_n` is high. The clock edge, `lba_n` and `baa_n` have no effect in this mode.
- R3: A high `burst_on` on a clock edge puts the block in burst mode from the next cycle. In burst mode, a clock edge that sees `lba_n` and `ce_n` low captures `addr_in` as the start word. The first word is flagged valid `LAT_CYC` clock edges after that loading edge.
- R4: Once the first word is valid, each clock edge that sees `baa_n` low advances the word offset by one. While `baa_n` is high the offset holds, and `baa_n` is ignored during the initial latency.
- R5: The offset is the low 5 bits of `mem_addr` and wraps modulo 32, so a start at offset 8 gives 8, 9, …, 31, 0, …, 7, 8. Bits 19 to 5 keep the loaded value for the whole burst.
- R6: A 5-bit burst count is 0 at the start word. `last_n` is low exactly while the word with count 31 is presented with the burst valid and `ce_n` low. One more advance returns the offset to the start word.
- R7: A clock edge with `ce_n` high in burst mode ends the burst. `data_valid` goes low at once with `ce_n`, and the block stays in burst mode. A later load starts a new burst at the address present on that load edge.
- R8: A high `burst_off` on a clock edge ends any burst and returns the block to asynchronous mode on the next cycle. When both strobes are high on the same edge, `burst_off` wins.
- R9: Pulling the reset input low in the middle of a burst ends it at once and leaves the block in asynchronous mode.
- R10: When `lba_n` and `baa_n` are both low on the same edge, the block loads the new start address and does not advance.
- R11: During a valid burst, `data_valid` also requires `oe_n` low. With `oe_n` high the address still advances on `baa_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Burst clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous |
| burst_on | input | 1 | Decoded strobe that enters burst mode |
| burst_off | input | 1 | Decoded strobe that leaves burst mode |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| lba_n | input | 1 | Active-low load of the burst start address |
| baa_n | input | 1 | Active-low burst address advance |
| addr_in | input | 20 | Word address from the host |
| mem_addr | output | 20 | Word address to the array read port |
| data_valid | output | 1 | Word at the array port is valid for the host |
| last_n | output | 1 | Active-low flag for the 32nd word of a burst |

## Verification
The embedded properties check on every cycle that asynchronous mode passes the address straight through with the last-word flag high, that an advance moves the offset by exactly one while the upper bits hold, and that a simultaneous load and advance only loads. They also check that a high `ce_n` ends the burst while keeping the mode, and that `burst_off` always wins. Only the bench's scenarios can show the full wrapped order from offsets 2 and 8, the placement of `last_n` on the 32nd word and the restart from the start word after it, and the exact latency to the first valid word. They also show that a reset in the middle of a burst leaves the block in asynchronous mode. A reference model in the bench follows the same stimulus as random traffic, so it also catches mode and enable interleavings that no single property covers.

// File: rtl/brs_pkg.sv
package brs_pkg;

   typedef enum logic {
      MODE_ASYNC = 1'b0,
      MODE_BURST = 1'b1
   } rd_mode_t;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      int unsigned w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction

endpackage

// File: rtl/brs_mode_ctrl.sv
module brs_mode_ctrl
   import brs_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     on_cmd,
   input  logic     off_cmd,
   output rd_mode_t mode
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MODE_ASYNC;
      end else if (off_cmd) begin
         mode <= MODE_ASYNC;
      end else if (on_cmd) begin
         mode <= MODE_BURST;
      end
   end

   // R8: the leave strobe always wins
   p_off_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      off_cmd |=> mode == MODE_ASYNC);

   // R3: the enter strobe alone enters burst mode
   p_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (on_cmd && !off_cmd) |=> mode == MODE_BURST);

endmodule

// File: rtl/brs_latency.sv
module brs_latency
   import brs_pkg::*;
#(
   parameter int unsigned LAT_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic ready
);

   generate
      if (LAT_CYC == 0) begin : g_zero_lat
         assign ready = 1'b1;
      end else begin : g_count_lat
         localparam int unsigned LW = cnt_width(LAT_CYC);
         localparam logic [LW-1:0] LOAD_VAL = LW'(LAT_CYC);

         logic [LW-1:0] remain;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               remain <= '0;
            end else if (start) begin
               remain <= LOAD_VAL;
            end else if (remain != '0) begin
               remain <= remain - 1'b1;
            end
         end

         assign ready = (remain == '0);

         // R3: no word is ready on the cycle after a load
         p_wait_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> !ready);
      end
   endgenerate

endmodule

// File: rtl/brs_wrap_ctr.sv
module brs_wrap_ctr #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned OFS_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] word_addr,
   output logic              at_last
);

   localparam int unsigned HI_W = ADDR_W - OFS_W;

   logic [HI_W-1:0]  base_hi;
   logic [OFS_W-1:0] base_ofs;
   logic [OFS_W-1:0] burst_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_hi   <= '0;
         base_ofs  <= '0;
         burst_cnt <= '0;
      end else if (load) begin
         base_hi   <= start_addr[ADDR_W-1:OFS_W];
         base_ofs  <= start_addr[OFS_W-1:0];
         burst_cnt <= '0;
      end else if (step) begin
         burst_cnt <= burst_cnt + 1'b1;
      end
   end

   assign word_addr = {base_hi, OFS_W'(base_ofs + burst_cnt)};
   assign at_last   = &burst_cnt;

   // R6: stepping from the last word returns to the starting offset
   p_wrap_home_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && at_last) |=> word_addr[OFS_W-1:0] == base_ofs);

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
   import brs_pkg::*;
#(
   parameter int unsigned ADDR_W  = 20,
   parameter int unsigned OFS_W   = 5,
   parameter int unsigned LAT_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              burst_on,
   input  logic              burst_off,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              lba_n,
   input  logic              baa_n,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              data_valid,
   output logic              last_n
);

   generate
      if (OFS_W < 1 || ADDR_W <= OFS_W) begin : g_bad_width
         $error("burst_read_seq: ADDR_W must exceed OFS_W, and OFS_W must be at least 1");
      end
      if (LAT_CYC > 255) begin : g_bad_lat
         $error("burst_read_seq: LAT_CYC above supported range");
      end
   endgenerate

   rd_mode_t          mode;
   logic              in_burst_mode;
   logic              burst_act;
   logic              lat_ready;
   logic              do_load;
   logic              do_step;
   logic [ADDR_W-1:0] word_addr;
   logic              at_last;
   logic              burst_live;

   brs_mode_ctrl u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .on_cmd  (burst_on),
      .off_cmd (burst_off),
      .mode    (mode)
   );

   assign in_burst_mode = (mode == MODE_BURST);
   assign do_load = in_burst_mode && !burst_off && !ce_n && !lba_n;
   assign do_step = in_burst_mode && !burst_off && !ce_n && lba_n
                    && burst_act && lat_ready && !baa_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_act <= 1'b0;
      end else if (burst_off || !in_burst_mode || ce_n) begin
         burst_act <= 1'b0;
      end else if (do_load) begin
         burst_act <= 1'b1;
      end
   end

   brs_latency #(.LAT_CYC(LAT_CYC)) u_lat (
      .clk   (clk),
      .rst_n (rst_n),
      .start (do_load),
      .ready (lat_ready)
   );

   brs_wrap_ctr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_wrap (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (do_load),
      .step       (do_step),
      .start_addr (addr_in),
      .word_addr  (word_addr),
      .at_last    (at_last)
   );

   assign burst_live = in_burst_mode && burst_act;

   always_comb begin
      mem_addr   = burst_live ? word_addr : addr_in;
      data_valid = 1'b0;
      if (!ce_n && !oe_n) begin
         data_valid = in_burst_mode ? (burst_act && lat_ready) : 1'b1;
      end
      last_n = !(burst_live && lat_ready && !ce_n && at_last);
   end

   // R2: asynchronous mode passes the address through and keeps last_n high
   p_async_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_ASYNC) |-> (last_n && mem_addr == addr_in));

   // R4: an advance moves the offset by exactly one
   p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (do_step ##1 burst_live) |->
         mem_addr[OFS_W-1:0] == OFS_W'($past(mem_addr[OFS_W-1:0]) + 1'b1));

   // R5: upper address bits hold while no new load happens
   p_hold_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((burst_live && !do_load) ##1 burst_live) |->
         $stable(mem_addr[ADDR_W-1:OFS_W]));

   // R6: the last-word flag only appears during a live burst with chip enable low
   p_last_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !last_n |-> (burst_live && !ce_n));

   // R7: chip enable high ends the burst but keeps the mode
   p_ce_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_burst_mode && ce_n && !burst_off) |=> (in_burst_mode && !burst_act));

   // R10: a load on the same edge as an advance only loads
   p_load_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (do_load && !baa_n) |=> mem_addr == $past(addr_in));

endmodule

// File: tb/tb_burst_read_seq.sv
module tb_burst_read_seq;

   localparam int AW  = 20;
   localparam int LAT = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          burst_on, burst_off, ce_n, oe_n, lba_n, baa_n;
   logic [AW-1:0] addr_in;
   logic [AW-1:0] mem_addr;
   logic          data_valid, last_n;

   burst_read_seq #(.ADDR_W(AW), .OFS_W(5), .LAT_CYC(LAT)) dut (
      .clk(clk), .rst_n(rst_n), .burst_on(burst_on), .burst_off(burst_off),
      .ce_n(ce_n), .oe_n(oe_n), .lba_n(lba_n), .baa_n(baa_n),
      .addr_in(addr_in), .mem_addr(mem_addr), .data_valid(data_valid),
      .last_n(last_n)
   );

   always #5 clk = ~clk;

   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;
   string cur_req = "R1";

   // reference model state
   bit          m_mode, m_act;
   int          m_lat;
   logic [AW-1:0] m_base;
   logic [4:0]  m_cnt;

   function automatic logic [AW-1:0] exp_addr();
      if (m_mode && m_act) return {m_base[AW-1:5], 5'(m_base[4:0] + m_cnt)};
      return addr_in;
   endfunction

   function automatic logic exp_dv();
      if (ce_n || oe_n) return 1'b0;
      if (!m_mode) return 1'b1;
      return m_act && (m_lat == 0);
   endfunction

   function automatic logic exp_last();
      return !(m_mode && m_act && (m_lat == 0) && !ce_n && (m_cnt == 5'd31));
   endfunction

   task automatic model_reset();
      m_mode = 0; m_act = 0; m_lat = 0; m_cnt = '0; m_base = '0;
   endtask

   task automatic model_edge();
      bit nm;
      nm = burst_off ? 1'b0 : (burst_on ? 1'b1 : m_mode);
      if (burst_off || !m_mode || ce_n) begin
         m_act = 0;
         if (m_lat > 0) m_lat--;
      end else if (!lba_n) begin
         m_act = 1; m_base = addr_in; m_cnt = '0; m_lat = LAT;
      end else if (m_act) begin
         if (m_lat > 0) m_lat--;
         else if (!baa_n) m_cnt = m_cnt + 1'b1;
      end
      m_mode = nm;
   endtask

   task automatic compare();
      logic [AW-1:0] ea;
      logic ed, el;
      ea = exp_addr(); ed = exp_dv(); el = exp_last();
      checks++;
      if (mem_addr !== ea) begin
         errors++;
         $display("FAIL %s mem_addr actual=%05h expected=%05h",
                  m_mode ? "R5" : "R2", mem_addr, ea);
      end
      checks++;
      if (data_valid !== ed) begin
         errors++;
         $display("FAIL %s data_valid actual=%0b expected=%0b", cur_req, data_valid, ed);
      end
      checks++;
      if (last_n !== el) begin
         errors++;
         $display("FAIL R6 last_n actual=%0b expected=%0b", last_n, el);
      end
   endtask

   task automatic cyc(input logic on, off, ce, oe, lb, ba, input logic [AW-1:0] a);
      @(negedge clk);
      burst_on = on; burst_off = off; ce_n = ce; oe_n = oe;
      lba_n = lb; baa_n = ba; addr_in = a;
      #1 compare();
      @(posedge clk);
      model_edge();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      #1 compare();
      @(negedge clk);
      #1 compare();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      #2000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [AW-1:0] ra;
      void'($urandom(32'd4711));
      burst_on = 0; burst_off = 0; ce_n = 1; oe_n = 1; lba_n = 1; baa_n = 1;
      addr_in = '0; rst_n = 1'b1;
      model_reset();
      // R1 reset state
      cur_req = "R1";
      do_reset();
      cyc(0, 0, 0, 0, 1, 1, 20'h12345);
      // R2 asynchronous reads ignore lba_n and baa_n
      cur_req = "R2";
      for (int i = 0; i < 12; i++)
         cyc(0, 0, i[0], i[1], i[2], 1'b0, 20'(i * 20'h01357));
      // R3 enter burst, load at offset 2 and wait out the latency
      cur_req = "R3";
      cyc(1, 0, 1, 0, 1, 1, 20'h0);
      cyc(0, 0, 0, 0, 0, 1, 20'hABC42);
      for (int i = 0; i < LAT; i++) cyc(0, 0, 0, 0, 1, 0, 20'h00000);
      // R4 R5 R6 advance through the wrap, the last word and the restart
      cur_req = "R4";
      for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 1, 0, 20'hFFFFF);
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 1, 20'h0);
      // R11 output enable high gates valid but not the advance
      cur_req = "R11";
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 1, 0, 20'h0);
      // R10 load and advance on the same edge
      cur_req = "R10";
      cyc(0, 0, 0, 0, 0, 0, 20'h5551F);
      cyc(0, 0, 0, 0, 1, 0, 20'h0);
      // R7 chip enable high ends the burst, reload at offset 8
      cur_req = "R7";
      cyc(0, 0, 1, 0, 1, 0, 20'h0);
      cyc(0, 0, 1, 0, 0, 0, 20'h0);
      cyc(0, 0, 0, 0, 0, 1, 20'h7E008);
      for (int i = 0; i < LAT + 34; i++) cyc(0, 0, 0, 0, 1, 0, 20'h0);
      // R8 leave strobe wins over enter strobe
      cur_req = "R8";
      cyc(1, 1, 0, 0, 1, 0, 20'h0);
      cyc(0, 0, 0, 0, 0, 0, 20'h33333);
      cyc(0, 0, 0, 0, 1, 0, 20'h44444);
      // R9 reset in the middle of a burst
      cur_req = "R9";
      cyc(1, 0, 0, 0, 1, 1, 20'h0);
      cyc(0, 0, 0, 0, 0, 1, 20'h12310);
      for (int i = 0; i < LAT + 3; i++) cyc(0, 0, 0, 0, 1, 0, 20'h0);
      do_reset();
      cyc(0, 0, 0, 0, 1, 0, 20'h98765);
      // random traffic against the model (R2 R3 R4 R5 R6 R7 R8 R11)
      cur_req = "R3/R4/R7/R11";
      cyc(1, 0, 0, 0, 1, 1, 20'h0);
      for (int i = 0; i < 4000; i++) begin
         ra = 20'($urandom);
         if ($urandom_range(0, 999) == 0) do_reset();
         cyc(($urandom_range(0, 99) < 2), ($urandom_range(0, 199) == 0),
             ($urandom_range(0, 99) < 4), ($urandom_range(0, 99) < 15),
             ($urandom_range(0, 99) >= 3), ($urandom_range(0, 99) < 15), ra);
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule